// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block decides whether a write-type command to a serial NOR flash may run. The SPI front end decodes a command and presents it as a one-cycle strobe. The strobes cover:

- setting or clearing the write-enable latch
- writing the status byte, with its data
- page program, with an address
- sector erase, with an address
- whole-chip erase

The block holds the status byte, which contains the lock bit, three block-protect bits, the write-enable latch and a busy flag. It also watches the active-low protect pin. For every status write, program or erase it returns one response: accepted or rejected.

Protection works at two levels. The block-protect value fences off the top sectors of a 512 KB array made of eight 64 KB sectors. The lock bit, together with a low protect pin, freezes the status byte itself. An accepted operation raises busy for a fixed number of cycles, which stands in for the array timing. While busy is high, every write-type strobe is dropped.

Top module: `flash_wprot_top`

## Requirements
- R1: After reset the status byte reads 0x00 and no response is signalled. Bits 6 and 5 of the status byte always read 0.
- R2: When not busy, a latch-set strobe sets status bit 1 (write-enable latch) and a latch-clear strobe clears it. A program, erase or status write never sets the latch.
- R3: With status bit 7 (lock) at 0, a status write made while the latch is set is accepted at either pin level. After it, bit 7 takes data bit 7 and bits 4:2 (block-protect value) take data bits 4:2.
- R4: With the lock bit at 1 and the protect pin high, a status write made while the latch is set is accepted.
- R5: With the lock bit at 1 and the protect pin low, every status write is rejected and bits 7 and 4:2 keep their values. The result is the same whether the lock bit was set before the pin went low or after.
- R6: Driving the protect pin high is the only way out of the hardware lock. After that, a status write that clears the lock bit is accepted.
- R7: A status write, program or erase made while the latch is clear is rejected.
- R8: The sector is address bits 18:16. A block-protect value N protects the top floor(2^N/2) of the eight sectors, capped at eight. Program and sector erase into a protected sector are rejected.
- R9: With the latch set, program and sector erase into an unprotected sector are accepted.
- R10: A whole-chip erase is accepted only when the latch is set and the block-protect value is 0.
- R11: Every response, whether accepted or rejected, leaves the latch cleared.
- R12: An accepted operation holds status bit 0 (busy) high for BUSY_CYCLES cycles. While busy, all write-type strobes are ignored: there is no response and no state change.
- R13: The response (respValid high, respAccept showing the verdict) appears in the cycle after the strobe. The status byte shows the new state in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWren | input | 1 | Set write-enable latch strobe |
| cmdWrdi | input | 1 | Clear write-enable latch strobe |
| cmdWrsr | input | 1 | Status write strobe |
| srData | input | 8 | Status write data |
| cmdProg | input | 1 | Page program strobe |
| cmdSecErase | input | 1 | Sector erase strobe |
| cmdBulkErase | input | 1 | Whole-chip erase strobe |
| cmdAddr | input | ADDR_W | Byte address for program or sector erase |
| protPinN | input | 1 | Active-low write-protect pin |
| statusOut | output | 8 | {lock, 0, 0, bp[2:0], latch, busy} |
| respValid | output | 1 | One-cycle response pulse |
| respAccept | output | 1 | Verdict qualified by respValid |

## Verification
The hardest state to reach is the hardware lock entered in each of its two orders, followed by an attempt to clear the lock bit while the pin is still low. Hitting it needs the lock set, the latch set again, the busy window waited out and the pin placed at the right moment. Directed sequences walk both orders and then release the pin. Random stimulus with rare pin toggles keeps revisiting the lock while block-protect values and addresses vary.

// File: rtl/flash_wprot_pkg.sv
package flash_wprot_pkg;
  localparam int SR_W = 8;
  localparam logic [SR_W-1:0] SR_KEEP = 8'b1001_1100;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadSr;
    logic startBusy;
  } strobe_t;
endpackage

// File: rtl/flash_wprot_ctrl.sv
module flash_wprot_ctrl
  import flash_wprot_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdWrsr,
  input  logic              cmdProg,
  input  logic              cmdSecErase,
  input  logic              cmdBulkErase,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              protPinN,
  input  logic              lockIn,
  input  logic [2:0]        bpIn,
  input  logic              welIn,
  input  logic              busyIn,
  output strobe_t           strobe,
  output logic              respValid,
  output logic              respAccept
);
  localparam logic [SECT_W:0] SECTORS = (SECT_W+1)'(1 << SECT_W);

  logic [SECT_W-1:0] sectorIdx;
  logic [SECT_W:0]   protCount;
  logic              sectorProt, hwLock, anyWrite, verdict;

  assign sectorIdx = SECT_W'(cmdAddr >> (ADDR_W - SECT_W));
  assign hwLock    = lockIn & ~protPinN;
  assign anyWrite  = cmdWrsr | cmdProg | cmdSecErase | cmdBulkErase;

  always_comb begin
    if (bpIn == 3'd0)                   protCount = '0;
    else if (int'(bpIn) - 1 >= SECT_W)  protCount = SECTORS;
    else                                protCount = (SECT_W+1)'(1 << (bpIn - 3'd1));
  end

  assign sectorProt = ({1'b0, sectorIdx} >= (SECTORS - protCount)) && (protCount != '0);

  always_comb begin
    if (cmdWrsr)                        verdict = welIn & ~hwLock;
    else if (cmdProg || cmdSecErase)    verdict = welIn & ~sectorProt;
    else                                verdict = welIn & (bpIn == 3'd0);
  end

  always_comb begin
    strobe = '0;
    if (!busyIn) begin
      strobe.loadSr    = cmdWrsr & verdict;
      strobe.startBusy = anyWrite & verdict;
      strobe.clrWel    = anyWrite | cmdWrdi;
      strobe.setWel    = cmdWren & ~anyWrite & ~cmdWrdi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respAccept <= 1'b0;
    end else begin
      respValid  <= ~busyIn & anyWrite;
      respAccept <= ~busyIn & anyWrite & verdict;
    end
  end
endmodule

// File: rtl/flash_wprot_dp.sv
module flash_wprot_dp
  import flash_wprot_pkg::*;
#(
  parameter int BUSY_CYCLES = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strobe,
  input  logic [SR_W-1:0] srData,
  output logic            lockOut,
  output logic [2:0]      bpOut,
  output logic            welOut,
  output logic            busyOut,
  output logic [SR_W-1:0] statusOut
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [SR_W-1:0] srQ;
  logic            welQ;
  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srQ     <= '0;
      welQ    <= 1'b0;
      busyCnt <= '0;
    end else begin
      if (strobe.loadSr) srQ <= srData & SR_KEEP;
      if (strobe.clrWel)      welQ <= 1'b0;
      else if (strobe.setWel) welQ <= 1'b1;
      if (strobe.startBusy)       busyCnt <= CNT_W'(BUSY_CYCLES);
      else if (busyCnt != '0)     busyCnt <= busyCnt - 1'b1;
    end
  end

  assign lockOut   = srQ[7];
  assign bpOut     = srQ[4:2];
  assign welOut    = welQ;
  assign busyOut   = (busyCnt != '0);
  assign statusOut = (srQ & SR_KEEP) | {6'b0, welQ, busyOut};
endmodule

// File: rtl/flash_wprot_top.sv
module flash_wprot_top
  import flash_wprot_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int SECT_W      = 3,
  parameter int BUSY_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdWrsr,
  input  logic [7:0]        srData,
  input  logic              cmdProg,
  input  logic              cmdSecErase,
  input  logic              cmdBulkErase,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              protPinN,
  output logic [7:0]        statusOut,
  output logic              respValid,
  output logic              respAccept
);
  strobe_t    strobe;
  logic       lockQ, welQ, busyQ;
  logic [2:0] bpQ;

  flash_wprot_ctrl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdWrsr(cmdWrsr),
    .cmdProg(cmdProg), .cmdSecErase(cmdSecErase), .cmdBulkErase(cmdBulkErase),
    .cmdAddr(cmdAddr), .protPinN(protPinN),
    .lockIn(lockQ), .bpIn(bpQ), .welIn(welQ), .busyIn(busyQ),
    .strobe(strobe), .respValid(respValid), .respAccept(respAccept)
  );

  flash_wprot_dp #(.BUSY_CYCLES(BUSY_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srData(srData),
    .lockOut(lockQ), .bpOut(bpQ), .welOut(welQ), .busyOut(busyQ),
    .statusOut(statusOut)
  );
endmodule

// File: rtl/flash_wprot_chk.sv
module flash_wprot_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdWren,
  input logic       cmdWrsr,
  input logic       cmdProg,
  input logic       cmdSecErase,
  input logic       cmdBulkErase,
  input logic       protPinN,
  input logic [7:0] statusOut,
  input logic       respValid,
  input logic       respAccept
);
  logic anyWr;
  assign anyWr = cmdWrsr | cmdProg | cmdSecErase | cmdBulkErase;

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[6:5] == 2'b00);

  a_r5_locked_reject: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrsr && !statusOut[0] && statusOut[7] && !protPinN) |=> (respValid && !respAccept));

  a_r5_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrsr && !statusOut[0] && statusOut[7] && !protPinN) |=> $stable({statusOut[7], statusOut[4:2]}));

  a_r7_no_latch_reject: assert property (@(posedge clk) disable iff (!rstN)
    (anyWr && !statusOut[0] && !statusOut[1]) |=> (respValid && !respAccept));

  a_r10_bulk_protected: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBulkErase && !cmdWrsr && !cmdProg && !cmdSecErase && !statusOut[0] && statusOut[4:2] != 3'd0)
      |=> !respAccept);

  a_r11_latch_cleared: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !statusOut[1]);

  a_r12_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[0] && (anyWr || cmdWren)) |=> !respValid);

  a_r12_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respAccept) |-> statusOut[0]);
endmodule

bind flash_wprot_top flash_wprot_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdWren(cmdWren), .cmdWrsr(cmdWrsr),
  .cmdProg(cmdProg), .cmdSecErase(cmdSecErase), .cmdBulkErase(cmdBulkErase),
  .protPinN(protPinN), .statusOut(statusOut),
  .respValid(respValid), .respAccept(respAccept)
);

// File: tb/flash_wprot_top_tb.sv
module flash_wprot_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 19;
  localparam int BUSY = 5;
  localparam int OP_NONE = 0, OP_WREN = 1, OP_WRDI = 2, OP_WRSR = 3,
                 OP_PROG = 4, OP_SE = 5, OP_BE = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdWren = 0, cmdWrdi = 0, cmdWrsr = 0, cmdProg = 0, cmdSecErase = 0, cmdBulkErase = 0;
  logic [7:0] srData = '0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic protPinN = 1'b1;
  logic [7:0] statusOut;
  logic respValid, respAccept;

  int total = 0, bad = 0;
  logic mLock = 0, mWel = 0;
  logic [2:0] mBp = '0;
  int mCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wprot_top #(.ADDR_W(ADDR_W), .SECT_W(3), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rstN(rstN), .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdWrsr(cmdWrsr),
    .srData(srData), .cmdProg(cmdProg), .cmdSecErase(cmdSecErase),
    .cmdBulkErase(cmdBulkErase), .cmdAddr(cmdAddr), .protPinN(protPinN),
    .statusOut(statusOut), .respValid(respValid), .respAccept(respAccept)
  );

  function automatic bit isProt(input logic [2:0] bp, input logic [ADDR_W-1:0] a);
    int cnt;
    int sec = int'(a[18:16]);
    if (bp == 0) cnt = 0;
    else if (bp >= 4) cnt = 8;
    else cnt = 1 << (bp - 1);
    return (cnt != 0) && (sec >= 8 - cnt);
  endfunction

  function automatic logic [7:0] expStatus();
    return {mLock, 2'b00, mBp, mWel, (mCnt != 0)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int op, input logic [7:0] d, input logic [ADDR_W-1:0] a, input string tag);
    bit expValid = 0, expAcc = 0, ok;
    cmdWren = (op == OP_WREN); cmdWrdi = (op == OP_WRDI); cmdWrsr = (op == OP_WRSR);
    cmdProg = (op == OP_PROG); cmdSecErase = (op == OP_SE); cmdBulkErase = (op == OP_BE);
    srData = d; cmdAddr = a;
    if (mCnt != 0) mCnt--;
    else begin
      case (op)
        OP_WREN: mWel = 1;
        OP_WRDI: mWel = 0;
        OP_WRSR, OP_PROG, OP_SE, OP_BE: begin
          if (op == OP_WRSR)      ok = mWel && !(mLock && !protPinN);
          else if (op == OP_BE)   ok = mWel && (mBp == 0);
          else                    ok = mWel && !isProt(mBp, a);
          if (ok && op == OP_WRSR) begin mLock = d[7]; mBp = d[4:2]; end
          if (ok) mCnt = BUSY;
          mWel = 0; expValid = 1; expAcc = ok;
        end
        default: ;
      endcase
    end
    @(negedge clk);
    cmdWren = 0; cmdWrdi = 0; cmdWrsr = 0; cmdProg = 0; cmdSecErase = 0; cmdBulkErase = 0;
    check(tag, respValid, expValid, "respValid");
    if (expValid) check(tag, respAccept, expAcc, "respAccept");
    check(tag, statusOut, expStatus(), "status");
  endtask

  task automatic idleOut();
    while (mCnt != 0) step(OP_NONE, 8'h00, '0, "R12");
  endtask

  function automatic string tagOf(input int op);
    case (op)
      OP_WREN, OP_WRDI: return "R2";
      OP_WRSR: return (mLock && !protPinN) ? "R5" : "R3";
      OP_PROG, OP_SE: return "R8";
      OP_BE: return "R10";
      default: return "R12";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", statusOut, 8'h00, "reset status");
    check("R1", respValid, 1'b0, "reset respValid");

    // R7 writes without latch
    step(OP_WRSR, 8'h9C, '0, "R7");
    step(OP_PROG, 8'h00, 19'h00000, "R7");
    // R2 latch set/clear
    step(OP_WREN, 8'h00, '0, "R2");
    step(OP_WRDI, 8'h00, '0, "R2");
    // R3 lock=0, pin low: accepted, fields taken
    protPinN = 1'b0;
    step(OP_WREN, 8'h00, '0, "R3");
    step(OP_WRSR, 8'h9C, '0, "R3");
    idleOut();
    // R5 order 1: lock set while pin low -> try to clear lock
    step(OP_WREN, 8'h00, '0, "R5");
    step(OP_WRSR, 8'h00, '0, "R5");
    check("R5", statusOut[7], 1'b1, "lock kept");
    // R6 release pin, then clear lock; R4 lock=1 pin high write accepted
    protPinN = 1'b1;
    step(OP_WREN, 8'h00, '0, "R6");
    step(OP_WRSR, 8'h84, '0, "R4");
    idleOut();
    // R5 order 2: lock already set, pin goes low afterwards
    protPinN = 1'b0;
    step(OP_WREN, 8'h00, '0, "R5");
    step(OP_WRSR, 8'h00, '0, "R5");
    protPinN = 1'b1;
    step(OP_WREN, 8'h00, '0, "R6");
    step(OP_WRSR, 8'h08, '0, "R6");   // bp=2: sectors 6,7 protected
    idleOut();
    check("R6", statusOut, 8'h08, "unlocked bp=2");
    // R8 / R9 sector protection
    step(OP_WREN, 8'h00, '0, "R8");
    step(OP_PROG, 8'h00, 19'h7_1234, "R8");
    step(OP_WREN, 8'h00, '0, "R8");
    step(OP_SE, 8'h00, 19'h6_0000, "R8");
    step(OP_WREN, 8'h00, '0, "R9");
    step(OP_PROG, 8'h00, 19'h5_FFFF, "R9");
    // R12 strobes during busy ignored
    step(OP_WREN, 8'h00, '0, "R12");
    step(OP_PROG, 8'h00, 19'h0_0000, "R12");
    idleOut();
    // R10 whole-chip erase
    step(OP_WREN, 8'h00, '0, "R10");
    step(OP_BE, 8'h00, '0, "R10");
    step(OP_WREN, 8'h00, '0, "R10");
    step(OP_WRSR, 8'h00, '0, "R10");
    idleOut();
    step(OP_WREN, 8'h00, '0, "R10");
    step(OP_BE, 8'h00, '0, "R10");
    idleOut();
    // R8 bp=7 protects everything, bp=1 only sector 7
    step(OP_WREN, 8'h00, '0, "R8");
    step(OP_WRSR, 8'h1C, '0, "R8");
    idleOut();
    step(OP_WREN, 8'h00, '0, "R8");
    step(OP_SE, 8'h00, 19'h0_0000, "R8");
    step(OP_WREN, 8'h00, '0, "R8");
    step(OP_WRSR, 8'h04, '0, "R8");
    idleOut();
    step(OP_WREN, 8'h00, '0, "R9");
    step(OP_SE, 8'h00, 19'h6_0000, "R9");
    idleOut();

    // random phase (R11 and R13 covered by every checked response)
    for (int i = 0; i < 4000; i++) begin
      int op;
      if ($urandom % 25 == 0) protPinN = ~protPinN;
      op = ($urandom % 3 == 0) ? OP_WREN : int'($urandom % 7);
      step(op, 8'($urandom), ADDR_W'($urandom), tagOf(op));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule